// File: doc/BRIEF.md
# Processor Cold/Warm Reset Sequencer

This block sits beside a processor on the system board side and generates the two reset inputs the processor expects: an active-low cold reset, which fully initialises the part, and an active-low logical reset, which restarts it without disturbing its clocking. Every count is in system-clock cycles. After power is reported good, cold reset is held for a long interval (65536 cycles by default). It is then released, and the logical reset follows a fixed number of cycles later (16 by default). Every release happens at a rising clock edge.

While running, a warm-reset request pulses only the logical reset, and cold reset stays released. A cold-reset request restarts the whole sequence. A cold request wins over a warm request. A warm request that arrives while any reset is in progress is dropped. Loss of power-good forces both resets low at once, without waiting for a clock, and clears all progress. A lock flag tells the board logic to freeze the processor's configuration straps (clock divide ratio, byte order, bus compatibility mode). It rises before cold reset is first released. A done flag reports that both resets are released.

Top module: `proc_reset_seq`

## Requirements
- R1: While `pwr_good` is low, `cold_rst_n`, `logic_rst_n`, `straps_locked` and `seq_done` are all 0. A falling `pwr_good` forces them to 0 at once, without waiting for a clock edge.
- R2: After `pwr_good` rises, `cold_rst_n` goes high on rising edge number COLD_HOLD+SYNC_STAGES. The first SYNC_STAGES edges pass `pwr_good` through the synchroniser.
- R3: `logic_rst_n` goes high exactly GAP_CYCLES rising edges after the edge that releases `cold_rst_n`. `logic_rst_n` is never high while `cold_rst_n` is low. Both outputs change only at rising edges, apart from the forced assertion in R1.
- R4: In the running state, the edge that samples `warm_req`=1 drives `logic_rst_n` low. `logic_rst_n` goes high again GAP_CYCLES edges later. `cold_rst_n` stays high throughout.
- R5: In the running state, the edge that samples `cold_req`=1 drives both resets low. `cold_rst_n` goes high COLD_HOLD edges later, and `logic_rst_n` goes high GAP_CYCLES edges after that.
- R6: If `cold_req` and `warm_req` are sampled high at the same edge, the cold sequence of R5 runs and the warm request has no effect.
- R7: A `warm_req` sampled while cold reset is held, during the gap, or during a warm pulse (including the edge that ends that pulse) is ignored. The current sequence keeps its length, and nothing is replayed afterwards.
- R8: `straps_locked` rises on edge SYNC_STAGES+1 after `pwr_good` rises. It is therefore high before `cold_rst_n` is first released, and it never falls while `pwr_good` stays high.
- R9: A `cold_req` sampled in any phase, including the gap or a warm pulse, restarts the full cold hold from that edge. The gap then follows.
- R10: `seq_done` is 1 exactly when both resets are released. After a power loss, the next power-up repeats the full R2/R3 timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| pwr_good | input | 1 | Supplies stable; low acts as asynchronous clear |
| cold_req | input | 1 | Request full cold-reset sequence (sampled at rising edge) |
| warm_req | input | 1 | Request logical-reset pulse (sampled at rising edge) |
| cold_rst_n | output | 1 | Active-low cold reset to the processor |
| logic_rst_n | output | 1 | Active-low logical reset to the processor |
| straps_locked | output | 1 | Configuration straps must be held stable |
| seq_done | output | 1 | Both resets released |

## Verification
Two kinds of event can land on one edge: a cold and a warm request sampled together, and a warm request sampled on the edge that ends a warm pulse or a gap. The table-driven bench provokes both by scheduling each request at an exact edge index relative to the start of a sequence. It judges the outcome by counting, for each output, the edges after which it reads low until the sequence completes. A wrongly honoured request shows up as a longer count, either in that vector or in the idle vector that follows it.

// File: rtl/prs_pkg.sv
package prs_pkg;

  typedef enum logic [1:0] {
    PH_COLD = 2'd0,
    PH_GAP  = 2'd1,
    PH_RUN  = 2'd2,
    PH_WARM = 2'd3
  } prs_phase_e;

  // Bits needed to hold the largest terminal count (limit - 1).
  function automatic int unsigned prs_ctr_width(int unsigned a, int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

  // Terminal count of the hold counter for a given phase.
  function automatic int unsigned prs_phase_last(prs_phase_e ph,
                                                 int unsigned cold_hold,
                                                 int unsigned gap_cycles);
    case (ph)
      PH_COLD:          return cold_hold - 1;
      PH_GAP, PH_WARM:  return gap_cycles - 1;
      default:          return 0;
    endcase
  endfunction

endpackage

// File: rtl/prs_pwr_sync.sv
module prs_pwr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic pg_ok
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign pg_ok = chain[STAGES-1];

  initial begin
    assert_stages_min_R2: assert (STAGES >= 2);
  end
endmodule

// File: rtl/prs_hold_ctr.sv
module prs_hold_ctr #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         clear,
  input  logic [W-1:0] last,
  output logic         at_last
);
  logic [W-1:0] cnt;

  assign at_last = (cnt == last);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)               cnt <= '0;
    else if (clear || at_last) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  // Count never runs past the terminal value of the current phase.
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!arst_n)
    cnt <= last);
endmodule

// File: rtl/prs_strap_lock.sv
module prs_strap_lock (
  input  logic clk,
  input  logic arst_n,
  input  logic pg_ok,
  output logic locked
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)    locked <= 1'b0;
    else if (pg_ok) locked <= 1'b1;
  end
endmodule

// File: rtl/proc_reset_seq.sv
module proc_reset_seq #(
  parameter int unsigned COLD_HOLD   = 65536,
  parameter int unsigned GAP_CYCLES  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic pwr_good,
  input  logic cold_req,
  input  logic warm_req,
  output logic cold_rst_n,
  output logic logic_rst_n,
  output logic straps_locked,
  output logic seq_done
);
  import prs_pkg::*;

  localparam int unsigned CW = prs_ctr_width(COLD_HOLD, GAP_CYCLES);

  prs_phase_e phase, phase_nxt;
  logic       pg_ok;
  logic       at_last;
  logic       ctr_clear;
  logic [CW-1:0] ctr_last;

  // Named internal events, used by the assertions.
  logic cold_start, warm_start, warm_dropped;

  prs_pwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (pwr_good),
    .pg_ok  (pg_ok)
  );

  prs_strap_lock u_lock (
    .clk    (clk),
    .arst_n (pwr_good),
    .pg_ok  (pg_ok),
    .locked (straps_locked)
  );

  assign ctr_last = CW'(prs_phase_last(phase, COLD_HOLD, GAP_CYCLES));

  prs_hold_ctr #(.W(CW)) u_ctr (
    .clk     (clk),
    .arst_n  (pwr_good),
    .clear   (ctr_clear),
    .last    (ctr_last),
    .at_last (at_last)
  );

  assign cold_start   = pg_ok && cold_req;
  assign warm_start   = pg_ok && !cold_req && warm_req && (phase == PH_RUN);
  assign warm_dropped = pg_ok && !cold_req && warm_req && (phase != PH_RUN);

  always_comb begin
    phase_nxt = phase;
    ctr_clear = 1'b0;
    if (!pg_ok || cold_start) begin
      phase_nxt = PH_COLD;
      ctr_clear = 1'b1;
    end else begin
      case (phase)
        PH_COLD: if (at_last) phase_nxt = PH_GAP;
        PH_GAP:  if (at_last) phase_nxt = PH_RUN;
        PH_WARM: if (at_last) phase_nxt = PH_RUN;
        default: begin
          ctr_clear = 1'b1;
          if (warm_start) phase_nxt = PH_WARM;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) phase <= PH_COLD;
    else           phase <= phase_nxt;
  end

  assign cold_rst_n  = (phase != PH_COLD);
  assign logic_rst_n = (phase == PH_RUN);
  assign seq_done    = (phase == PH_RUN);

  // ---------------- assertions ----------------
  assert_order_R3: assert property (@(posedge clk) disable iff (!pwr_good)
    !cold_rst_n |-> !logic_rst_n);

  assert_gap_after_cold_R3: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(cold_rst_n) |-> !logic_rst_n);

  assert_cold_hold_R2: assert property (@(posedge clk) disable iff (!pwr_good)
    (pg_ok && !cold_req && phase == PH_COLD && !at_last) |=> !cold_rst_n);

  assert_warm_keeps_cold_R4: assert property (@(posedge clk) disable iff (!pwr_good)
    warm_start |=> (cold_rst_n && !logic_rst_n));

  assert_cold_wins_R6: assert property (@(posedge clk) disable iff (!pwr_good)
    cold_start |=> (!cold_rst_n && !logic_rst_n));

  assert_warm_dropped_R7: assert property (@(posedge clk) disable iff (!pwr_good)
    (warm_dropped && phase == PH_COLD && !at_last) |=> !cold_rst_n);

  assert_lock_first_R8: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(cold_rst_n) |-> straps_locked);

  assert_lock_holds_R8: assert property (@(posedge clk) disable iff (!pwr_good)
    !$fell(straps_locked));

  assert_done_released_R10: assert property (@(posedge clk) disable iff (!pwr_good)
    seq_done |-> (cold_rst_n && logic_rst_n));
endmodule

// File: tb/proc_reset_seq_tb.sv
`timescale 1ns/1ps
module proc_reset_seq_tb;
  localparam int C    = 64;
  localparam int G    = 16;
  localparam int S    = 2;
  localparam real TCK = 8.0;

  logic clk = 1'b0;
  logic pwr_good = 1'b0, cold_req = 1'b0, warm_req = 1'b0;
  logic cold_rst_n, logic_rst_n, straps_locked, seq_done;

  int checks = 0, errors = 0;

  always #(TCK/2) clk = ~clk;

  proc_reset_seq #(.COLD_HOLD(C), .GAP_CYCLES(G), .SYNC_STAGES(S)) u_dut (
    .clk(clk), .pwr_good(pwr_good), .cold_req(cold_req), .warm_req(warm_req),
    .cold_rst_n(cold_rst_n), .logic_rst_n(logic_rst_n),
    .straps_locked(straps_locked), .seq_done(seq_done));

  // c0/w0: requests sampled at edge 0; wedge/cedge: extra request edge (-1 none);
  // ecl/ell: expected edges after which cold / logical reset reads low.
  typedef struct packed {
    logic c0; logic w0; int wedge; int cedge; int ecl; int ell; int rq;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b0, 1'b1, -1,    -1,    0,   G,           4},  // R4 warm pulse
    '{1'b1, 1'b0, -1,    -1,    C,   C+G,         5},  // R5 cold restart
    '{1'b1, 1'b1, -1,    -1,    C,   C+G,         6},  // R6 same-edge priority
    '{1'b0, 1'b0, -1,    -1,    0,   0,           7},  // R7 idle baseline
    '{1'b1, 1'b0, 10,    -1,    C,   C+G,         7},  // R7 warm during cold hold
    '{1'b1, 1'b0, C+3,   -1,    C,   C+G,         7},  // R7 warm during gap
    '{1'b0, 1'b1, 5,     -1,    0,   G,           7},  // R7 warm during warm
    '{1'b0, 1'b1, G,     -1,    0,   G,           7},  // R7 warm on releasing edge
    '{1'b0, 1'b0, -1,    -1,    0,   0,           7},  // R7 nothing replayed
    '{1'b0, 1'b1, -1,    6,     C,   C+6+G,       9},  // R9 cold during warm
    '{1'b1, 1'b0, -1,    C+4,   2*C, 2*C+4+G,     9},  // R9 cold during gap
    '{1'b0, 1'b0, -1,    -1,    0,   0,           9}   // R9 settles to run
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Power-up from pwr_good low: counts low edges and checks lock timing.
  task automatic power_up(input string tag);
    int cl = 0, ll = 0, lock_at = -1, done_bad = 0;
    @(negedge clk);
    pwr_good = 1'b1;
    for (int k = 1; k < 4*C; k++) begin
      @(posedge clk); #2;
      if (!cold_rst_n) cl++;
      if (!logic_rst_n) ll++;
      if (straps_locked && lock_at < 0) lock_at = k;
      if (seq_done !== (cold_rst_n && logic_rst_n)) done_bad++;
      if (logic_rst_n) break;
    end
    check({tag, " R2 cold low edges"}, cl, C+S-1);
    check({tag, " R3 logical low edges"}, ll, C+S-1+G);
    check({tag, " R8 lock edge"}, lock_at, S+1);
    check({tag, " R10 done tracks releases"}, done_bad, 0);
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int cl = 0, ll = 0, lock_bad = 0, order_bad = 0;
    @(negedge clk);
    cold_req = v.c0; warm_req = v.w0;
    for (int k = 0; k < 1000; k++) begin
      @(posedge clk); #2;
      if (!cold_rst_n) cl++;
      if (!logic_rst_n) ll++;
      if (!straps_locked) lock_bad++;
      if (!cold_rst_n && logic_rst_n) order_bad++;
      cold_req = (v.cedge == k+1);
      warm_req = (v.wedge == k+1);
      if (logic_rst_n && k >= v.wedge && k >= v.cedge) break;
    end
    cold_req = 1'b0; warm_req = 1'b0;
    check($sformatf("vec%0d R%0d cold low edges", idx, v.rq), cl, v.ecl);
    check($sformatf("vec%0d R%0d logical low edges", idx, v.rq), ll, v.ell);
    check($sformatf("vec%0d R8 lock held", idx), lock_bad, 0);
    check($sformatf("vec%0d R3 release order", idx), order_bad, 0);
  endtask

  initial begin
    #(TCK*200000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #2;
    check("R1 cold at power-off", int'(cold_rst_n), 0);
    check("R1 logical at power-off", int'(logic_rst_n), 0);
    check("R1 lock at power-off", int'(straps_locked), 0);
    check("R1 done at power-off", int'(seq_done), 0);

    power_up("first");

    for (int i = 0; i < 12; i++) run_vec(VECS[i], i);

    // R1 asynchronous assertion mid-cycle while running
    @(posedge clk); #2;
    check("R10 running before drop", int'(seq_done), 1);
    pwr_good = 1'b0;
    #1;
    check("R1 cold forced low", int'(cold_rst_n), 0);
    check("R1 logical forced low", int'(logic_rst_n), 0);
    check("R1 lock cleared", int'(straps_locked), 0);
    check("R1 done cleared", int'(seq_done), 0);

    // R10 power loss in the middle of a cold hold, then full restart
    repeat (2) @(posedge clk);
    @(negedge clk); pwr_good = 1'b1;
    repeat (20) @(posedge clk);
    #2; pwr_good = 1'b0;
    repeat (3) @(posedge clk);
    power_up("R10 restart");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule